// File: doc/BRIEF.md
# Write Data Pacing Sequencer

This block schedules the data phase of a block write on a bus that carries address and data over the same wires. The cycle in which `start` is accepted is the address cycle. After it come a programmable number of idle cycles (0 to 7). Then the block walks through the data beats of one block. Each beat gets a one-cycle `beat_vld` strobe and a beat index. Beats are spaced by one of nine fixed pacing codes, each a repeating run of data cycles followed by idle cycles.

A block is four beats when the bus is in its wide (doubleword) mode and eight beats in its narrow (word) mode. `done` pulses once after the final beat. The codes above 8 are reserved. Presenting one of them makes the block raise `err` for a single cycle, and no transfer takes place. All settings are captured in the address cycle, so the surrounding bus logic may change them freely while a transfer runs. Data storage and parity are left to the surrounding logic.

Top module: `write_pacer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after release, `beat_vld`, `done` and `err` are 0.
- R2: `start` is taken only while the block is idle. A `start` seen during a transfer, including one with a reserved code, changes nothing on the outputs.
- R3: With gap value G, the cycles 1..G after the address cycle carry no beat, and the first beat (index 0) appears in cycle G+1. G=0 puts the first beat in the cycle right after the address cycle.
- R4: With `narrow`=0 a block has exactly 4 beats. With `narrow`=1 it has exactly 8 beats.
- R5: Codes 0 to 3 pace beats as follows. Code 0 gives a beat every cycle. Code 1 repeats 2 beats then 1 idle cycle. Code 2 repeats 2 beats then 2 idle cycles. Code 3 repeats 1 beat then 1 idle cycle.
- R6: Codes 4 to 8 pace beats as follows. Code 4 repeats 2 beats then 3 idle cycles. Code 5 repeats 2 beats then 4 idle. Code 6 repeats 1 beat then 2 idle. Code 7 repeats 2 beats then 6 idle. Code 8 repeats 1 beat then 3 idle.
- R7: `beat_vld` is high only on beat cycles. `beat_idx` counts 0, 1, 2 … over the beats of a block, rising by one per beat.
- R8: `done` is high for exactly one cycle: the cycle right after the last beat. `beat_vld` is low in that cycle. No trailing idle cycles of the pattern come before it.
- R9: A start with a code from 9 to 15 gives a one-cycle `err` pulse in the next cycle. It produces no beats and no `done`, and the block stays ready for a new start.
- R10: Code, gap and width are captured in the address cycle. Changing them during a transfer has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Address cycle marker; taken only when idle |
| pat_code | input | CODE_W (4) | Pacing code, 0..8 valid |
| gap | input | GAP_W (3) | Idle cycles between address and first beat |
| narrow | input | 1 | 1 = narrow bus, 8 beats; 0 = wide bus, 4 beats |
| beat_vld | output | 1 | High in each data beat cycle |
| beat_idx | output | IDX_W (3) | Index of the current beat |
| done | output | 1 | One-cycle pulse after the last beat |
| err | output | 1 | One-cycle pulse for a reserved code |

## Verification
Every valid code is run once at both widths, at the smallest and the largest gap. This separates the run length from the idle length of each pattern. It also shows whether the block stops at the last beat or wrongly waits out a trailing idle stretch. Random transfers mix codes, gaps and widths, and during a transfer they toggle `start` and change the settings. This exposes a sequencer that re-samples its inputs or restarts. Reserved codes are applied both from idle and in the middle of a transfer. That tells apart the error path from the path where the request is ignored.

// File: rtl/pace_pkg.sv
package pace_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_GAP   = 2'd1,
      ST_DATA  = 2'd2,
      ST_SPACE = 2'd3
   } pace_state_t;

   // one pacing pattern: a run of data cycles, then idle cycles
   typedef struct packed {
      logic [1:0] run;
      logic [2:0] idle;
      logic       bad;
   } pace_pat_t;

endpackage

// File: rtl/pace_decode.sv
module pace_decode
   import pace_pkg::*;
#(
   parameter int CODE_W = 4
) (
   input  logic [CODE_W-1:0] code,
   output pace_pat_t         pat
);

   initial begin
      assert (CODE_W >= 4) else $error("pace_decode: CODE_W must hold codes 0..8");
   end

   always_comb begin
      pat = '{run: 2'd1, idle: 3'd0, bad: 1'b0};
      case (code)
         CODE_W'(0): pat = '{run: 2'd1, idle: 3'd0, bad: 1'b0};
         CODE_W'(1): pat = '{run: 2'd2, idle: 3'd1, bad: 1'b0};
         CODE_W'(2): pat = '{run: 2'd2, idle: 3'd2, bad: 1'b0};
         CODE_W'(3): pat = '{run: 2'd1, idle: 3'd1, bad: 1'b0};
         CODE_W'(4): pat = '{run: 2'd2, idle: 3'd3, bad: 1'b0};
         CODE_W'(5): pat = '{run: 2'd2, idle: 3'd4, bad: 1'b0};
         CODE_W'(6): pat = '{run: 2'd1, idle: 3'd2, bad: 1'b0};
         CODE_W'(7): pat = '{run: 2'd2, idle: 3'd6, bad: 1'b0};
         CODE_W'(8): pat = '{run: 2'd1, idle: 3'd3, bad: 1'b0};
         default:    pat = '{run: 2'd1, idle: 3'd0, bad: 1'b1};
      endcase
   end

endmodule

// File: rtl/pace_seq.sv
module pace_seq
   import pace_pkg::*;
#(
   parameter int GAP_W        = 3,
   parameter int BEATS_WIDE   = 4,
   parameter int BEATS_NARROW = 8,
   localparam int IDX_W       = $clog2(BEATS_NARROW)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [GAP_W-1:0] gap,
   input  logic             narrow,
   input  pace_pat_t        pat,
   output logic             beat_vld,
   output logic [IDX_W-1:0] beat_idx,
   output logic             done,
   output logic             err
);

   localparam logic [IDX_W-1:0] LAST_WIDE   = IDX_W'(BEATS_WIDE - 1);
   localparam logic [IDX_W-1:0] LAST_NARROW = IDX_W'(BEATS_NARROW - 1);

   pace_state_t      state_q;
   logic [GAP_W-1:0] gcnt_q;
   logic [2:0]       scnt_q;
   logic [1:0]       rpos_q;
   logic [1:0]       run_q;
   logic [2:0]       idle_q;
   logic [IDX_W-1:0] beat_q;
   logic [IDX_W-1:0] last_q;
   logic             done_q;
   logic             err_q;
   logic             start_ok;

   assign start_ok = start && (state_q == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         gcnt_q  <= '0;
         scnt_q  <= '0;
         rpos_q  <= '0;
         run_q   <= 2'd1;
         idle_q  <= '0;
         beat_q  <= '0;
         last_q  <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  if (pat.bad) begin
                     err_q <= 1'b1;
                  end else begin
                     run_q  <= pat.run;
                     idle_q <= pat.idle;
                     last_q <= narrow ? LAST_NARROW : LAST_WIDE;
                     beat_q <= '0;
                     rpos_q <= '0;
                     if (gap == '0) begin
                        state_q <= ST_DATA;
                     end else begin
                        gcnt_q  <= gap - 1'b1;
                        state_q <= ST_GAP;
                     end
                  end
               end
            end
            ST_GAP: begin
               if (gcnt_q == '0) state_q <= ST_DATA;
               else              gcnt_q  <= gcnt_q - 1'b1;
            end
            ST_DATA: begin
               if (beat_q == last_q) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  beat_q <= beat_q + 1'b1;
                  if (rpos_q == run_q - 2'd1) begin
                     rpos_q <= '0;
                     if (idle_q != '0) begin
                        scnt_q  <= idle_q - 3'd1;
                        state_q <= ST_SPACE;
                     end
                  end else begin
                     rpos_q <= rpos_q + 2'd1;
                  end
               end
            end
            ST_SPACE: begin
               if (scnt_q == '0) state_q <= ST_DATA;
               else              scnt_q  <= scnt_q - 3'd1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign beat_vld = (state_q == ST_DATA);
   assign beat_idx = beat_q;
   assign done     = done_q;
   assign err      = err_q;

   // R3
   gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ok && gap == '0 && !pat.bad) |=> (beat_vld && beat_idx == '0));

   // R7
   idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_vld |=> (!beat_vld || beat_idx == IDX_W'($past(beat_idx) + 1'b1)));

   // R8
   done_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!beat_vld && $past(beat_vld)));

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!beat_vld && !done));

   // R9
   err_no_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !beat_vld);

   // R2
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !start_ok) |=> !err);

endmodule

// File: rtl/write_pacer.sv
module write_pacer
   import pace_pkg::*;
#(
   parameter int CODE_W       = 4,
   parameter int GAP_W        = 3,
   parameter int BEATS_WIDE   = 4,
   parameter int BEATS_NARROW = 8,
   localparam int IDX_W       = $clog2(BEATS_NARROW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CODE_W-1:0] pat_code,
   input  logic [GAP_W-1:0]  gap,
   input  logic              narrow,
   output logic              beat_vld,
   output logic [IDX_W-1:0]  beat_idx,
   output logic              done,
   output logic              err
);

   initial begin
      assert (BEATS_WIDE >= 1 && BEATS_NARROW >= BEATS_WIDE)
         else $error("write_pacer: beat counts out of range");
      assert (GAP_W >= 1) else $error("write_pacer: GAP_W must be at least 1");
   end

   pace_pat_t pat;

   pace_decode #(.CODE_W(CODE_W)) u_dec (
      .code (pat_code),
      .pat  (pat)
   );

   pace_seq #(
      .GAP_W        (GAP_W),
      .BEATS_WIDE   (BEATS_WIDE),
      .BEATS_NARROW (BEATS_NARROW)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .gap      (gap),
      .narrow   (narrow),
      .pat      (pat),
      .beat_vld (beat_vld),
      .beat_idx (beat_idx),
      .done     (done),
      .err      (err)
   );

endmodule

// File: tb/sim_write_pacer.sv
`timescale 1ns/1ps
module sim_write_pacer;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       start;
   logic [3:0] pat_code;
   logic [2:0] gap;
   logic       narrow;
   logic       beat_vld;
   logic [2:0] beat_idx;
   logic       done;
   logic       err;

   int nvec = 0;
   int nbad = 0;
   bit finished = 1'b0;

   bit ev [0:127];
   int ei [0:127];
   int done_k;

   always #2.5 clk = ~clk;

   write_pacer u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .pat_code(pat_code),
      .gap(gap), .narrow(narrow), .beat_vld(beat_vld), .beat_idx(beat_idx),
      .done(done), .err(err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s at %0t: got %0d expected %0d", req, $time, act, exp);
      end
   endtask

   function automatic int run_of(input int code);
      case (code)
         0, 3, 6, 8: return 1;
         default:    return 2;
      endcase
   endfunction

   function automatic int idle_of(input int code);
      case (code)
         0: return 0;  1: return 1;  2: return 2;  3: return 1;  4: return 3;
         5: return 4;  6: return 2;  7: return 6;  default: return 3;
      endcase
   endfunction

   // expected timeline, k = cycles after the address cycle
   task automatic build(input int code, input int g, input int nar);
      int nb, k, rp;
      for (int i = 0; i < 128; i++) begin ev[i] = 1'b0; ei[i] = 0; end
      nb = nar ? 8 : 4;
      k  = g + 1;
      rp = 0;
      for (int b = 0; b < nb; b++) begin
         ev[k] = 1'b1;
         ei[k] = b;
         done_k = k + 1;
         k++;
         rp++;
         if (rp == run_of(code)) begin
            rp = 0;
            k += idle_of(code);
         end
      end
   endtask

   task automatic run_xfer(input int code, input int g, input int nar,
                           input bit perturb, input string tag);
      int nbeats;
      @(negedge clk);
      start = 1'b1; pat_code = 4'(code); gap = 3'(g); narrow = nar[0];
      if (code > 8) begin
         for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            start = 1'b0;
            chk(err == (k == 1), "R9", int'(err), int'(k == 1));
            chk(!beat_vld && !done, "R9", int'(beat_vld | done), 0);
         end
         return;
      end
      build(code, g, nar);
      nbeats = 0;
      for (int k = 1; k <= done_k + 2; k++) begin
         @(negedge clk);
         chk(beat_vld == ev[k], (k <= g) ? "R3" : tag, int'(beat_vld), int'(ev[k]));
         if (ev[k] && beat_vld) begin
            nbeats++;
            chk(int'(beat_idx) == ei[k], "R7", int'(beat_idx), ei[k]);
         end
         chk(done == (k == done_k), "R8", int'(done), int'(k == done_k));
         chk(err == 1'b0, perturb ? "R2" : "R9", int'(err), 0);
         if (perturb && k < done_k) begin
            // R10 / R2: inputs move and start toggles while busy
            start    = 1'($urandom % 2);
            pat_code = 4'($urandom % 16);
            gap      = 3'($urandom % 8);
            narrow   = 1'($urandom % 2);
         end else begin
            start = 1'b0;
         end
      end
      chk(nbeats == (nar ? 8 : 4), "R4", nbeats, nar ? 8 : 4);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         nbad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      int code, g, nar;
      bit pert;
      void'($urandom(32'd2718));
      rst_n = 1'b0; start = 1'b0; pat_code = '0; gap = '0; narrow = 1'b0;
      repeat (3) @(negedge clk);
      // R1: quiet under reset, start held low
      chk(!beat_vld && !done && !err, "R1", int'(beat_vld | done | err), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!beat_vld && !done && !err, "R1", int'(beat_vld | done | err), 0);

      // directed: every valid code, both widths, gap extremes (R5, R6, R3, R4)
      for (int c = 0; c <= 8; c++) begin
         run_xfer(c, 0, 0, 1'b0, (c <= 3) ? "R5" : "R6");
         run_xfer(c, 7, 1, 1'b0, (c <= 3) ? "R5" : "R6");
      end
      // R9: reserved codes from idle, then a normal transfer still works
      run_xfer(9, 0, 0, 1'b0, "R9");
      run_xfer(15, 3, 1, 1'b0, "R9");
      run_xfer(2, 1, 0, 1'b0, "R9");
      // R10: settings change during a transfer
      run_xfer(7, 5, 1, 1'b1, "R10");
      run_xfer(0, 0, 0, 1'b1, "R10");

      // random mix
      for (int n = 0; n < 400; n++) begin
         code = $urandom % 10;
         if (code == 9) code = 9 + ($urandom % 7);
         g    = $urandom % 8;
         nar  = $urandom % 2;
         pert = 1'($urandom % 2);
         run_xfer(code, g, nar, pert, pert ? "R10" : ((code <= 3) ? "R5" : "R6"));
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

endmodule